// File: doc/BRIEF.md
# Linked Descriptor DMA Channel Engine

This block is one DMA channel that walks a chain of descriptors held in memory. Each descriptor is 16 bytes: four 32-bit words read in the order command, source address, target address, count. The channel moves the number of transfer units that the descriptor asks for, one unit at a time. A unit is 1, 2, 4, 16, 32, 64 or 128 bytes. Each unit goes through a single 32-bit memory port as read/write beat pairs. When the descriptor has its link bit set, the channel goes on to the next descriptor. That descriptor sits at the chain base plus a 16-byte-granular offset, taken from the top byte of the count word.

Software loads the descriptor address and writes the enable bit in the control/status register. The channel latches the chain base at that point and fetches the first descriptor. The channel has three ways to end. It can reach a descriptor without the link bit, and it then reports end of chain. It can find a misaligned address, and it then reports an address error and halts. It can be stopped by software at the next unit boundary. The interrupt output is a level that stays high until software writes the control/status register.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads 0, irq_o is low and no memory request is raised.
- R2: Registers are 32-bit words selected by word index: 0 source, 1 target, 2 count, 3 request type, 4 control/status, 5 command, 6 descriptor address. While the channel is idle, the written values read back unchanged.
- R3: Writing control/status with bit 0 set while idle latches the descriptor address as chain base. The channel then reads four words at that address, offsets +0, +4, +8, +12, into command, source, target and count.
- R4: Command bits 10:8 pick the unit size (0=4 B, 1=1 B, 2=2 B, 3=16 B, 4=32 B, 5=64 B, 6 or 7=128 B). Units of 4 bytes or more move as size/4 word beats, each with a full byte strobe 4'hF, and the word read from the source is written to the target.
- R5: For 1-byte and 2-byte units, the source lane is picked by source address bits 1:0. The byte or halfword is replicated across the write word, and the strobe marks only the target lane: 4'b0001 shifted left by target bits 1:0 for bytes, 4'b0011 or 4'b1100 by target bit 1 for halfwords.
- R6: Command bit 23 adds the beat step (4 for word units, else the unit size) to the source address after each beat. Bit 22 does the same for the target address. With the bit clear, that address stays fixed.
- R7: Count bits 23:0 hold the remaining units. The channel decrements them once per completed unit, and they read back as the remaining count. A descriptor whose count is 0 completes without any data access.
- R8: A completed descriptor with command bit 0 set makes the channel fetch the next descriptor at base + 16 × count[31:24]. The descriptor-address register then reads that address.
- R9: A completed descriptor with command bit 0 clear sets status bit 3 (end of chain), clears bit 0 (enable) and leaves the channel idle.
- R10: A completed descriptor with command bit 1 set raises irq_o and status bit 1. Without that bit, completion leaves irq_o low.
- R11: A unit start with the source or target address not aligned to the unit size sets status bits 4 (address error) and 2 (halt), clears enable and raises irq_o, all without any data access.
- R12: Any write to control/status clears status bits 1 to 4 and irq_o. A write of 0 while running stops the channel at the next unit boundary and keeps the remaining count.
- R13: A memory request holds its address and direction until granted. Only one read is outstanding at a time, and every data write follows exactly one source read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request valid |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address (descriptor fetches use the descriptor address as given) |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte strobes |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| irq_o | output | 1 | Interrupt level |

## Verification
The checks take three things for granted. Memory returns exactly one rvalid pulse for each granted read and never an unsolicited one. Software writes registers other than control/status only while the channel is idle. Descriptor addresses are word aligned. The bench's memory model answers reads one cycle after a grant, and its grant pattern stalls requests regularly, so the hold-until-grant property gets exercised. The bench programs only idle registers and places every descriptor on a 16-byte boundary. Its only deliberate misalignment is the unit address used to provoke the address error.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned BE_W = DW / 8;
  localparam int unsigned NREG = 7;

  // register word indices
  localparam int R_SRC = 0;
  localparam int R_TGT = 1;
  localparam int R_CNT = 2;
  localparam int R_RT  = 3;
  localparam int R_CTL = 4;
  localparam int R_CMD = 5;
  localparam int R_DSC = 6;

  // command bits
  localparam int CMD_LINK  = 0;
  localparam int CMD_IE    = 1;
  localparam int CMD_SZ_LO = 8;
  localparam int CMD_DINC  = 22;
  localparam int CMD_SINC  = 23;

  // control/status bits
  localparam int CS_EN   = 0;
  localparam int CS_IRQ  = 1;
  localparam int CS_HALT = 2;
  localparam int CS_TT   = 3;
  localparam int CS_AERR = 4;
  localparam int CS_W    = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_UNIT, ST_RREQ, ST_RWAIT, ST_WREQ
  } dma_st_e;

  function automatic logic [2:0] unit_log2(input logic [2:0] code);
    unique case (code)
      3'd0:    return 3'd2;
      3'd1:    return 3'd0;
      3'd2:    return 3'd1;
      3'd3:    return 3'd4;
      3'd4:    return 3'd5;
      3'd5:    return 3'd6;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/dma_unit_dec.sv
module dma_unit_dec
  import dma_chan_pkg::*;
#(
  parameter int unsigned BEAT_W = 6
) (
  input  logic [2:0]        size_code_i,
  input  logic [6:0]        src_lo_i,
  input  logic [6:0]        tgt_lo_i,
  output logic [2:0]        log2_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic [2:0]        step_o,
  output logic              misalign_o
);
  logic [7:0] bytes;
  logic [7:0] mask;

  assign log2_o     = unit_log2(size_code_i);
  assign bytes      = 8'd1 << log2_o;
  assign mask       = bytes - 8'd1;
  assign beats_o    = (log2_o >= 3'd2) ? BEAT_W'(bytes >> 2) : BEAT_W'(1);
  assign step_o     = (log2_o >= 3'd2) ? 3'd4 : bytes[2:0];
  assign misalign_o = (|(src_lo_i & mask[6:0])) | (|(tgt_lo_i & mask[6:0]));
endmodule

// File: rtl/dma_lane.sv
module dma_lane
  import dma_chan_pkg::*;
(
  input  logic [2:0]      log2_i,
  input  logic [1:0]      src_lo_i,
  input  logic [1:0]      tgt_lo_i,
  input  logic [DW-1:0]   rdata_i,
  input  logic [DW-1:0]   hold_i,
  output logic [DW-1:0]   ext_o,
  output logic [DW-1:0]   wdata_o,
  output logic [BE_W-1:0] be_o
);
  // align the source lane down to bit 0
  assign ext_o = rdata_i >> {src_lo_i, 3'b000};

  always_comb begin
    unique case (log2_i)
      3'd0: begin
        wdata_o = {4{hold_i[7:0]}};
        be_o    = 4'b0001 << tgt_lo_i;
      end
      3'd1: begin
        wdata_o = {2{hold_i[15:0]}};
        be_o    = tgt_lo_i[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        wdata_o = hold_i;
        be_o    = 4'hF;
      end
    endcase
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned BEAT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] wr_sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic [BE_W-1:0] mem_be_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   tgt_o,
  output logic [AW-1:0]   dsc_o,
  output logic [DW-1:0]   cnt_o,
  output logic [DW-1:0]   rt_o,
  output logic [DW-1:0]   cmd_o,
  output logic [CS_W-1:0] stat_o
);
  localparam int unsigned OFF_W = DW - CNT_W;

  dma_st_e           st_q;
  logic [AW-1:0]     src_q, tgt_q, dsc_q, base_q;
  logic [DW-1:0]     cnt_q, rt_q, cmd_q, hold_q;
  logic [1:0]        fidx_q;
  logic [BEAT_W-1:0] beat_q;
  logic              en_q, irq_q, halt_q, tt_q, ar_q;

  logic [2:0]        log2;
  logic [BEAT_W-1:0] beats;
  logic [2:0]        step;
  logic              misalign;
  logic [DW-1:0]     ext, lane_wdata;
  logic [BE_W-1:0]   lane_be;
  logic [OFF_W-1:0]  next_off;

  assign next_off = cnt_q[DW-1:CNT_W];

  dma_unit_dec #(.BEAT_W(BEAT_W)) u_dec (
    .size_code_i (cmd_q[CMD_SZ_LO+2:CMD_SZ_LO]),
    .src_lo_i    (src_q[6:0]),
    .tgt_lo_i    (tgt_q[6:0]),
    .log2_o      (log2),
    .beats_o     (beats),
    .step_o      (step),
    .misalign_o  (misalign)
  );

  dma_lane u_lane (
    .log2_i   (log2),
    .src_lo_i (src_q[1:0]),
    .tgt_lo_i (tgt_q[1:0]),
    .rdata_i  (mem_rdata_i),
    .hold_i   (hold_q),
    .ext_o    (ext),
    .wdata_o  (lane_wdata),
    .be_o     (lane_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      tgt_q  <= '0;
      dsc_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      rt_q   <= '0;
      cmd_q  <= '0;
      hold_q <= '0;
      fidx_q <= '0;
      beat_q <= '0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
      tt_q   <= 1'b0;
      ar_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_sel_i[R_SRC]) src_q <= wdata_i[AW-1:0];
          if (wr_sel_i[R_TGT]) tgt_q <= wdata_i[AW-1:0];
          if (wr_sel_i[R_CNT]) cnt_q <= wdata_i;
          if (wr_sel_i[R_RT])  rt_q  <= wdata_i;
          if (wr_sel_i[R_CMD]) cmd_q <= wdata_i;
          if (wr_sel_i[R_DSC]) dsc_q <= wdata_i[AW-1:0];
          if (wr_sel_i[R_CTL] && wdata_i[CS_EN]) begin
            base_q <= dsc_q;
            fidx_q <= '0;
            st_q   <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_gnt_i) st_q <= ST_FWAIT;
        ST_FWAIT: begin
          if (mem_rvalid_i) begin
            unique case (fidx_q)
              2'd0:    cmd_q <= mem_rdata_i;
              2'd1:    src_q <= mem_rdata_i[AW-1:0];
              2'd2:    tgt_q <= mem_rdata_i[AW-1:0];
              default: cnt_q <= mem_rdata_i;
            endcase
            fidx_q <= fidx_q + 2'd1;
            st_q   <= (fidx_q == 2'd3) ? ST_UNIT : ST_FREQ;
          end
        end
        ST_UNIT: begin
          if (!en_q) begin
            st_q <= ST_IDLE;
          end else if (misalign) begin
            ar_q   <= 1'b1;
            halt_q <= 1'b1;
            irq_q  <= 1'b1;
            en_q   <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (cnt_q[CNT_W-1:0] == '0) begin
            if (cmd_q[CMD_IE]) irq_q <= 1'b1;
            if (cmd_q[CMD_LINK]) begin
              dsc_q  <= base_q + (AW'(next_off) << 4);
              fidx_q <= '0;
              st_q   <= ST_FREQ;
            end else begin
              tt_q <= 1'b1;
              en_q <= 1'b0;
              st_q <= ST_IDLE;
            end
          end else begin
            beat_q <= '0;
            st_q   <= ST_RREQ;
          end
        end
        ST_RREQ: if (mem_gnt_i) st_q <= ST_RWAIT;
        ST_RWAIT: begin
          if (mem_rvalid_i) begin
            hold_q <= ext;
            if (cmd_q[CMD_SINC]) src_q <= src_q + AW'(step);
            st_q <= ST_WREQ;
          end
        end
        ST_WREQ: begin
          if (mem_gnt_i) begin
            if (cmd_q[CMD_DINC]) tgt_q <= tgt_q + AW'(step);
            if (beat_q == beats - BEAT_W'(1)) begin
              cnt_q[CNT_W-1:0] <= cnt_q[CNT_W-1:0] - CNT_W'(1);
              st_q <= ST_UNIT;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
              st_q   <= ST_RREQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      // any control write clears status; enable follows bit 0
      if (wr_sel_i[R_CTL]) begin
        en_q   <= wdata_i[CS_EN];
        irq_q  <= 1'b0;
        halt_q <= 1'b0;
        tt_q   <= 1'b0;
        ar_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (st_q)
      ST_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dsc_q + AW'({fidx_q, 2'b00});
      end
      ST_RREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {src_q[AW-1:2], 2'b00};
      end
      ST_WREQ: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = {tgt_q[AW-1:2], 2'b00};
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = (st_q == ST_WREQ) ? lane_wdata : '0;
  assign mem_be_o    = (st_q == ST_WREQ) ? lane_be : '0;

  assign src_o  = src_q;
  assign tgt_o  = tgt_q;
  assign dsc_o  = dsc_q;
  assign cnt_o  = cnt_q;
  assign rt_o   = rt_q;
  assign cmd_o  = cmd_q;
  assign stat_o = {ar_q, tt_q, halt_q, irq_q, en_q};
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned BEAT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_idx_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            mem_req_o,
  input  logic            mem_gnt_i,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic [BE_W-1:0] mem_be_o,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            irq_o
);
  logic [NREG-1:0] wr_sel;
  logic [AW-1:0]   src_w, tgt_w, dsc_w;
  logic [DW-1:0]   cnt_w, rt_w, cmd_w;
  logic [CS_W-1:0] stat_w;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = reg_we_i && (reg_idx_i == 3'(g));
  end

  dma_seq #(.AW(AW), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_sel_i     (wr_sel),
    .wdata_i      (reg_wdata_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_be_o     (mem_be_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .src_o        (src_w),
    .tgt_o        (tgt_w),
    .dsc_o        (dsc_w),
    .cnt_o        (cnt_w),
    .rt_o         (rt_w),
    .cmd_o        (cmd_w),
    .stat_o       (stat_w)
  );

  always_comb begin
    unique case (reg_idx_i)
      3'(R_SRC): reg_rdata_o = DW'(src_w);
      3'(R_TGT): reg_rdata_o = DW'(tgt_w);
      3'(R_CNT): reg_rdata_o = cnt_w;
      3'(R_RT):  reg_rdata_o = rt_w;
      3'(R_CTL): reg_rdata_o = DW'(stat_w);
      3'(R_CMD): reg_rdata_o = cmd_w;
      3'(R_DSC): reg_rdata_o = DW'(dsc_w);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = stat_w[CS_IRQ];
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_gnt_i,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [3:0]  mem_be_o,
  input logic        irq_o,
  input logic [4:0]  stat_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R13

  AST_BE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> ($countones(mem_be_o) == 1) || (mem_be_o == 4'b0011)
                              || (mem_be_o == 4'b1100) || (mem_be_o == 4'hF)); // R5

  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[4] |-> stat_i[2] && !stat_i[0] && irq_o && !mem_req_o); // R11

  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[3] |-> !stat_i[0] && !mem_req_o); // R9
endmodule

bind dma_chan_engine dma_chan_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .irq_o      (irq_o),
  .stat_i     (stat_w)
);

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        irq;

  always #10 clk = ~clk;

  dma_chan_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_gnt_i(mem_gnt), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
  } wr_t;

  logic [31:0] mem [0:255];
  wr_t         exp_q[$];
  string       tag_q[$];
  logic [31:0] rd_log[$];
  int          n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, cyc = 0;
  bit          sb_off = 1'b0;
  bit          hs_v = 1'b0, hs_we = 1'b0;
  logic [31:0] hs_a, hs_d;
  logic [3:0]  hs_be;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (hs_v) begin
      if (hs_we) begin
        for (int b = 0; b < 4; b++)
          if (hs_be[b]) mem[hs_a[9:2]][8*b +: 8] = hs_d[8*b +: 8];
        wr_cnt++;
        if (!sb_off) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected write addr", hs_a, 32'h0);
          end else begin
            wr_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(hs_a == e.a, t, "write addr", hs_a, e.a);
            chk(hs_d == e.d, t, "write data", hs_d, e.d);
            chk(hs_be == e.be, t, "write strobe", {28'h0, hs_be}, {28'h0, e.be});
          end
        end
      end else begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[hs_a[9:2]];
        rd_log.push_back(hs_a);
        rd_cnt++;
      end
    end
    cyc++;
    mem_gnt = (cyc % 3) != 1;
    hs_v  = mem_req && mem_gnt;
    hs_we = mem_we;
    hs_a  = mem_addr;
    hs_d  = mem_wdata;
    hs_be = mem_be;
  end

  task automatic reg_wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] n);
    mem[a[9:2]] = c; mem[a[9:2]+1] = s; mem[a[9:2]+2] = t; mem[a[9:2]+3] = n;
  endtask

  task automatic push_w(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                        input string t);
    wr_t e;
    e.a = a; e.d = d; e.be = be;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic start(input logic [31:0] da);
    reg_wr(3'd6, da);
    reg_wr(3'd4, 32'h1);
  endtask

  task automatic wait_idle(input string rq);
    logic [31:0] d;
    bit to;
    to = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd4, d);
      if (!d[0]) begin to = 1'b0; break; end
    end
    if (to) chk(1'b0, rq, "channel never went idle", 32'h1, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, rem;
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A5A0000 + i * 32'h01030507;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      reg_rd(3'(i), d);
      chk(d == 32'h0, "R1", "register after reset", d, 32'h0);
    end
    chk(irq == 1'b0, "R1", "irq after reset", {31'h0, irq}, 32'h0);
    chk(mem_req == 1'b0, "R1", "request after reset", {31'h0, mem_req}, 32'h0);

    // R2 register readback while idle
    reg_wr(3'd0, 32'h1111_2220); reg_wr(3'd1, 32'h3333_4440);
    reg_wr(3'd2, 32'h0500_0007); reg_wr(3'd3, 32'h0000_0008);
    reg_wr(3'd5, 32'h00C0_0301); reg_wr(3'd6, 32'h0000_0040);
    reg_rd(3'd0, d); chk(d == 32'h1111_2220, "R2", "source reg", d, 32'h1111_2220);
    reg_rd(3'd1, d); chk(d == 32'h3333_4440, "R2", "target reg", d, 32'h3333_4440);
    reg_rd(3'd2, d); chk(d == 32'h0500_0007, "R2", "count reg", d, 32'h0500_0007);
    reg_rd(3'd3, d); chk(d == 32'h0000_0008, "R2", "request type reg", d, 32'h8);
    reg_rd(3'd5, d); chk(d == 32'h00C0_0301, "R2", "command reg", d, 32'h00C0_0301);
    reg_rd(3'd6, d); chk(d == 32'h0000_0040, "R2", "descriptor reg", d, 32'h40);

    // single descriptor, 4-byte units, both increment, interrupt enabled
    put_desc(32'h000, 32'h00C0_0002, 32'h100, 32'h200, 32'd3);
    for (int k = 0; k < 3; k++) push_w(32'h200 + 4*k, mem[(32'h100 >> 2) + k], 4'hF, "R4");
    rd_log.delete(); rd_cnt = 0; w0 = wr_cnt;
    start(32'h000);
    wait_idle("R9");
    chk(exp_q.size() == 0, "R4", "writes outstanding", exp_q.size(), 32'h0);
    for (int k = 0; k < 4; k++)
      chk(rd_log[k] == 32'(4*k), "R3", "descriptor fetch order", rd_log[k], 32'(4*k));
    chk(rd_cnt == 7, "R13", "reads per write", rd_cnt, 32'd7);
    reg_rd(3'd4, d); chk(d == 32'h0A, "R9", "status end of chain", d, 32'h0A);
    chk(irq == 1'b1, "R10", "irq after completion", {31'h0, irq}, 32'h1);
    reg_rd(3'd2, d); chk(d[23:0] == 24'h0, "R7", "remaining count", d, 32'h0);
    reg_rd(3'd0, d); chk(d == 32'h10C, "R6", "source advanced", d, 32'h10C);
    reg_rd(3'd1, d); chk(d == 32'h20C, "R6", "target advanced", d, 32'h20C);

    // R12 clear by writing zero
    reg_wr(3'd4, 32'h0);
    reg_rd(3'd4, d); chk(d == 32'h0, "R12", "status after clear", d, 32'h0);
    chk(irq == 1'b0, "R12", "irq after clear", {31'h0, irq}, 32'h0);

    // chain: 16-byte unit then byte units into a fixed target lane
    put_desc(32'h010, 32'h00C0_0301, 32'h120, 32'h240, 32'h0600_0001);
    put_desc(32'h070, 32'h0080_0102, 32'h161, 32'h2F2, 32'd3);
    for (int k = 0; k < 4; k++) push_w(32'h240 + 4*k, mem[(32'h120 >> 2) + k], 4'hF, "R4");
    for (int k = 0; k < 3; k++) push_w(32'h2F0, {4{byte_at(32'h161 + k)}}, 4'b0100, "R5");
    rd_log.delete();
    start(32'h010);
    wait_idle("R8");
    chk(exp_q.size() == 0, "R8", "chain writes outstanding", exp_q.size(), 32'h0);
    chk(rd_log[8] == 32'h070, "R8", "linked fetch address", rd_log[8], 32'h070);
    reg_rd(3'd6, d); chk(d == 32'h070, "R8", "descriptor reg after link", d, 32'h070);
    reg_rd(3'd4, d); chk(d == 32'h0A, "R10", "status after chain", d, 32'h0A);

    // halfword units, fixed source, target increments, no interrupt
    put_desc(32'h080, 32'h0040_0200, 32'h182, 32'h260, 32'd2);
    push_w(32'h260, {2{mem[32'h180 >> 2][31:16]}}, 4'b0011, "R6");
    push_w(32'h260, {2{mem[32'h180 >> 2][31:16]}}, 4'b1100, "R6");
    start(32'h080);
    wait_idle("R6");
    chk(exp_q.size() == 0, "R5", "halfword writes outstanding", exp_q.size(), 32'h0);
    reg_rd(3'd4, d); chk(d == 32'h08, "R10", "status without interrupt", d, 32'h08);
    chk(irq == 1'b0, "R10", "irq without enable", {31'h0, irq}, 32'h0);

    // misaligned 16-byte source
    put_desc(32'h090, 32'h00C0_0302, 32'h108, 32'h280, 32'd2);
    w0 = wr_cnt;
    start(32'h090);
    wait_idle("R11");
    reg_rd(3'd4, d); chk(d == 32'h16, "R11", "status address error", d, 32'h16);
    chk(irq == 1'b1, "R11", "irq on address error", {31'h0, irq}, 32'h1);
    chk(wr_cnt == w0, "R11", "no writes on error", wr_cnt, w0);
    reg_rd(3'd2, d); chk(d == 32'd2, "R11", "count untouched", d, 32'd2);

    // zero-count descriptor
    put_desc(32'h0A0, 32'h00C0_0002, 32'h100, 32'h2A0, 32'd0);
    w0 = wr_cnt;
    start(32'h0A0);
    wait_idle("R7");
    chk(wr_cnt == w0, "R7", "no writes for zero count", wr_cnt, w0);
    reg_rd(3'd4, d); chk(d == 32'h0A, "R7", "zero count completes", d, 32'h0A);

    // stop at a unit boundary
    put_desc(32'h0B0, 32'h0000_0000, 32'h100, 32'h2C0, 32'd40);
    sb_off = 1'b1;
    w0 = wr_cnt;
    start(32'h0B0);
    for (int i = 0; i < 500 && wr_cnt < w0 + 2; i++) @(negedge clk);
    reg_wr(3'd4, 32'h0);
    repeat (40) @(negedge clk);
    d = wr_cnt;
    repeat (40) @(negedge clk);
    chk(wr_cnt == d, "R12", "no writes after stop", wr_cnt, d);
    reg_rd(3'd4, d); chk(d == 32'h0, "R12", "status after stop", d, 32'h0);
    reg_rd(3'd2, rem);
    chk(rem + 32'(wr_cnt - w0) == 32'd40, "R12", "count kept after stop",
        rem + 32'(wr_cnt - w0), 32'd40);
    chk(rem != 0, "R12", "stopped before end", rem, 32'h1);
    sb_off = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule